// File: doc/BRIEF.md
# Digital Phase-Select Clock/Data Recovery

This block recovers bit timing for a serial stream from a set of equally spaced phases of a shared local clock. In every clock cycle the front end provides one sample of the line at each of `NPH` phases. The block chooses one of these phases to retime the data. It also compares the chosen sample with the samples at the two phases on either side of it, which gives an early or late vote whenever a data edge falls close to the chosen phase. A signed accumulator acts as a digital low-pass filter on these votes, so that input jitter does not move the sampling point. Only a sustained bias moves the selected phase, and each move is a single step. The phase index wraps around in both directions, so a steady frequency offset appears as a continuous phase ramp.

A mode input selects between two behaviours. When it is high, the loop follows the data. When it is low, the block locks to the local reference. In that mode the samples are ignored, the filter is cleared, the phase is frozen and the recovered bit holds its last value. A lock flag reports a run of cycles in which the phase did not move.

The control is a three-state machine:
- `ST_REF` means the block is locked to the reference.
- `ST_ACQ` means the block is acquiring, with the loop active and not yet quiet.
- `ST_LOCK` means the loop is active and the phase has been quiet for long enough.

The transitions are:
- any state goes to `ST_REF` while `rx_follow` is low;
- `ST_REF` goes to `ST_ACQ` on the first edge with `rx_follow` high;
- `ST_ACQ` goes to `ST_LOCK` when the quiet count reaches `lock_len_i`;
- `ST_LOCK` goes to `ST_ACQ` on any phase step.

Reset enters `ST_ACQ`.

Top module: `cdr_phase_pick`

## Requirements
- R1: While `rst_n` is low and after its release, before any further edge, `phase_o`=0, `bit_o`=0, `bit_vld_o`=0 and `locked_o`=0.
- R2: Let p be the selected phase, with neighbours p-1 and p+1 taken modulo `NPH`. The vote is +1 when `samp_i[p-1]` differs from `samp_i[p]` and `samp_i[p]` equals `samp_i[p+1]`. The vote is -1 when `samp_i[p-1]` equals `samp_i[p]` and `samp_i[p]` differs from `samp_i[p+1]`. In all other cases the vote is 0.
- R3: Each tracking edge adds the vote to a signed accumulator. If the sum reaches +T, `phase_o` steps up by one on that same edge and the accumulator returns to 0. If the sum reaches -T, `phase_o` steps down by one and the accumulator returns to 0. T is `thresh_i`, and a `thresh_i` of 0 acts as 1.
- R4: The phase index wraps modulo `NPH` in both directions: a step up from `NPH-1` gives 0, and a step down from 0 gives `NPH-1`.
- R5: On each edge with `rx_follow` high, `bit_o` takes `samp_i[p]` for the phase p in effect before that edge, and `bit_vld_o` becomes 1.
- R6: On each edge with `rx_follow` low, the block does the following:
  - `samp_i` is ignored;
  - the accumulator clears to 0;
  - `phase_o` and `bit_o` hold their values;
  - `bit_vld_o` becomes 0.
- R7: In `ST_ACQ`, each edge without a step increments a quiet count. When the count reaches `lock_len_i` (0 acts as 1), `locked_o` rises on that edge. `locked_o` falls on the edge that issues a step, and also on any edge with `rx_follow` low. The exit edge from `ST_REF` is not counted.
- R8: The state machine follows the transitions listed above, and `locked_o` is high exactly in `ST_LOCK`.
- R9: Under a constant one-sided vote, `phase_o` keeps ramping by one step every T edges, wrapping as it goes, for as long as the bias lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_follow | input | 1 | 1: follow the data; 0: lock to reference |
| samp_i | input | NPH | Line samples at each phase for this cycle |
| thresh_i | input | ACC_W-1 | Filter step threshold T |
| lock_len_i | input | LOCK_W | Quiet edges required before lock |
| bit_o | output | 1 | Retimed data bit |
| bit_vld_o | output | 1 | Retimed bit is valid |
| phase_o | output | $clog2(NPH) | Selected phase index |
| locked_o | output | 1 | Lock indicator |

## Verification
Every result of this block (the phase step, the retimed bit, the valid flag, the accumulator clear and the lock flag) is registered once. Each is therefore due at the first rising edge after the stimulus is applied. The bench applies stimulus after a falling edge and lets one rising edge pass. It then compares all outputs at the next falling edge against an arithmetic model that it advances once per edge. The model is driven by exhaustive 256-pattern sweeps under several thresholds, by phase-tracking ramps in both directions, by lock-length windows and by reference-mode bursts. Directed checks pin the exact edge of a wrap, of lock entry and of the post-reference accumulator clear.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    typedef enum logic [1:0] {
        ST_REF  = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2
    } cdr_st_e;
endpackage

// File: rtl/cdr_edge_vote.sv
module cdr_edge_vote #(
    parameter int NPH = 8,
    localparam int PW = $clog2(NPH)
) (
    input  logic [NPH-1:0] samp,
    input  logic [PW-1:0]  sel,
    output logic           vote_up,
    output logic           vote_dn,
    output logic           cur_bit
);
    localparam logic [PW-1:0] LAST = PW'(NPH - 1);

    logic [PW-1:0] idx_prv;
    logic [PW-1:0] idx_nxt;
    logic          s_prv;
    logic          s_nxt;

    always_comb begin
        idx_prv = (sel == '0)   ? LAST : sel - 1'b1;
        idx_nxt = (sel == LAST) ? '0   : sel + 1'b1;
        s_prv   = samp[idx_prv];
        s_nxt   = samp[idx_nxt];
        cur_bit = samp[sel];
        // edge sits just before the chosen phase: move later
        vote_up = (s_prv != cur_bit) && (cur_bit == s_nxt);
        // edge sits just after the chosen phase: move earlier
        vote_dn = (s_prv == cur_bit) && (cur_bit != s_nxt);
    end
endmodule

// File: rtl/cdr_loop_filt.sv
module cdr_loop_filt #(
    parameter int ACC_W = 5,
    localparam int THR_W = ACC_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             track,
    input  logic             vote_up,
    input  logic             vote_dn,
    input  logic [THR_W-1:0] thresh,
    output logic             step_up,
    output logic             step_dn
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W:0]   vote_s;
    logic signed [ACC_W:0]   sum_s;
    logic signed [ACC_W:0]   thr_s;
    logic [THR_W-1:0]        thr_eff;

    always_comb begin
        thr_eff = (thresh == '0) ? THR_W'(1) : thresh;
        thr_s   = signed'({2'b00, thr_eff});
        if (vote_up)
            vote_s = {{ACC_W{1'b0}}, 1'b1};
        else if (vote_dn)
            vote_s = '1;
        else
            vote_s = '0;
        sum_s   = {acc_q[ACC_W-1], acc_q} + vote_s;
        step_up = track && (sum_s >= thr_s);
        step_dn = track && (sum_s <= -thr_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (!track || step_up || step_dn)
            acc_q <= '0;
        else
            acc_q <= sum_s[ACC_W-1:0];
    end

    // R3: the accumulator never rests at or beyond the threshold it was checked against
    assert_acc_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (track && !step_up && !step_dn) |=> (acc_q < $past(thr_s)) && (acc_q > -$past(thr_s)));
endmodule

// File: rtl/cdr_phase_ctl.sv
module cdr_phase_ctl
    import cdr_pkg::*;
#(
    parameter int NPH    = 8,
    parameter int LOCK_W = 6,
    localparam int PW    = $clog2(NPH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track,
    input  logic              step_up,
    input  logic              step_dn,
    input  logic [LOCK_W-1:0] lock_len,
    output logic [PW-1:0]     phase,
    output logic              locked
);
    localparam logic [PW-1:0] LAST = PW'(NPH - 1);

    cdr_st_e            state_q;
    cdr_st_e            state_d;
    logic [PW-1:0]      phase_q;
    logic [LOCK_W-1:0]  quiet_q;
    logic [LOCK_W:0]    quiet_inc;
    logic               lock_hit;
    logic               stepped;

    always_comb begin
        stepped   = step_up || step_dn;
        quiet_inc = {1'b0, quiet_q} + 1'b1;
        lock_hit  = quiet_inc >= {1'b0, lock_len};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!track) begin
            state_d = ST_REF;
        end else begin
            unique case (state_q)
                ST_REF:  state_d = ST_ACQ;
                ST_ACQ:  state_d = stepped ? ST_ACQ : (lock_hit ? ST_LOCK : ST_ACQ);
                ST_LOCK: state_d = stepped ? ST_ACQ : ST_LOCK;
                default: state_d = ST_ACQ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_ACQ;
        else
            state_q <= state_d;
    end

    // datapath registers: phase index and quiet counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            quiet_q <= '0;
        end else begin
            if (step_up)
                phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            else if (step_dn)
                phase_q <= (phase_q == '0) ? LAST : phase_q - 1'b1;

            if (!track || stepped || state_q == ST_REF)
                quiet_q <= '0;
            else if (state_q == ST_ACQ && !quiet_inc[LOCK_W])
                quiet_q <= quiet_inc[LOCK_W-1:0];
        end
    end

    // outputs
    always_comb begin
        phase  = phase_q;
        locked = (state_q == ST_LOCK);
    end

    assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && phase_q == LAST) |=> phase_q == '0);
    assert_wrap_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && phase_q == '0) |=> phase_q == LAST);
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && phase_q != LAST) |=> phase_q == $past(phase_q) + 1'b1);
    assert_ref_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !track |=> state_q == ST_REF);
endmodule

// File: rtl/cdr_phase_pick.sv
module cdr_phase_pick #(
    parameter int NPH    = 8,
    parameter int ACC_W  = 5,
    parameter int LOCK_W = 6,
    localparam int PW    = $clog2(NPH),
    localparam int THR_W = ACC_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_follow,
    input  logic [NPH-1:0]    samp_i,
    input  logic [THR_W-1:0]  thresh_i,
    input  logic [LOCK_W-1:0] lock_len_i,
    output logic              bit_o,
    output logic              bit_vld_o,
    output logic [PW-1:0]     phase_o,
    output logic              locked_o
);
    logic vote_up;
    logic vote_dn;
    logic cur_bit;
    logic step_up;
    logic step_dn;
    logic bit_q;
    logic vld_q;

    cdr_edge_vote #(.NPH(NPH)) u_vote (
        .samp    (samp_i),
        .sel     (phase_o),
        .vote_up (vote_up),
        .vote_dn (vote_dn),
        .cur_bit (cur_bit)
    );

    cdr_loop_filt #(.ACC_W(ACC_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .track   (rx_follow),
        .vote_up (vote_up),
        .vote_dn (vote_dn),
        .thresh  (thresh_i),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    cdr_phase_ctl #(.NPH(NPH), .LOCK_W(LOCK_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .track    (rx_follow),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .lock_len (lock_len_i),
        .phase    (phase_o),
        .locked   (locked_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= rx_follow;
            if (rx_follow)
                bit_q <= cur_bit;
        end
    end

    assign bit_o     = bit_q;
    assign bit_vld_o = vld_q;

    assert_ref_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_follow |=> (!bit_vld_o && $stable(bit_o) && $stable(phase_o)));
    assert_step_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |=> !locked_o);
    assert_ref_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_follow |=> !locked_o);
endmodule

// File: tb/cdr_phase_pick_bench.sv
module cdr_phase_pick_bench;
    localparam int NPH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_follow = 1'b1;
    logic [7:0] samp_i = '0;
    logic [3:0] thresh_i = 4'd1;
    logic [5:0] lock_len_i = 6'd4;
    logic       bit_o;
    logic       bit_vld_o;
    logic [2:0] phase_o;
    logic       locked_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_phase, m_acc, m_st, m_q;
    logic m_bit, m_vld;

    always #4 clk = ~clk;

    cdr_phase_pick u_cdr_phase_pick (
        .clk(clk), .rst_n(rst_n), .rx_follow(rx_follow), .samp_i(samp_i),
        .thresh_i(thresh_i), .lock_len_i(lock_len_i), .bit_o(bit_o),
        .bit_vld_o(bit_vld_o), .phase_o(phase_o), .locked_o(locked_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // advance the model by one rising edge (states 0 ref, 1 acq, 2 lock)
    task automatic model_edge();
        int p, v, te, s;
        bit su, sd;
        if (!rx_follow) begin
            m_acc = 0; m_vld = 1'b0; m_q = 0; m_st = 0;
        end else begin
            p = m_phase;
            v = 0;
            if (samp_i[(p+7)%8] != samp_i[p] && samp_i[p] == samp_i[(p+1)%8]) v = 1;
            if (samp_i[(p+7)%8] == samp_i[p] && samp_i[p] != samp_i[(p+1)%8]) v = -1;
            te = (thresh_i == 0) ? 1 : int'(thresh_i);
            s  = m_acc + v;
            su = (s >= te);
            sd = (s <= -te);
            m_bit = samp_i[p];
            m_vld = 1'b1;
            m_acc = (su || sd) ? 0 : s;
            m_phase = (p + int'(su) - int'(sd) + 8) % 8;
            if (m_st == 0 || su || sd) begin
                m_st = 1; m_q = 0;
            end else if (m_st == 1) begin
                if (m_q + 1 >= int'(lock_len_i)) m_st = 2;
                if (m_q < 63) m_q = m_q + 1;
            end
        end
    endtask

    task automatic cyc(input logic [7:0] s, input logic fol);
        samp_i = s;
        rx_follow = fol;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R3 phase", int'(phase_o), m_phase);
        chk("R5 bit", int'(bit_o), int'(m_bit));
        chk("R6 valid", int'(bit_vld_o), int'(m_vld));
        chk("R7 locked", int'(locked_o), int'(m_st == 2));
    endtask

    function automatic logic [7:0] pat_up(input int p);
        pat_up = 8'hFF;
        pat_up[(p+7)%8] = 1'b0;
    endfunction

    function automatic logic [7:0] pat_dn(input int p);
        pat_dn = 8'hFF;
        pat_dn[(p+1)%8] = 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int p0;
        m_phase = 0; m_acc = 0; m_st = 1; m_q = 0; m_bit = 1'b0; m_vld = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 phase", int'(phase_o), 0);
        chk("R1 bit", int'(bit_o), 0);
        chk("R1 valid", int'(bit_vld_o), 0);
        chk("R1 locked", int'(locked_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 after release", int'(phase_o), 0);

        // R2: a single +1 vote with T=1 moves phase from 0 to 1
        thresh_i = 4'd1;
        samp_i = pat_up(0); rx_follow = 1'b1;
        @(posedge clk); model_edge(); @(negedge clk);
        chk("R2 up vote", int'(phase_o), 1);
        cyc(pat_dn(1), 1'b1);
        chk("R2 down vote", int'(phase_o), 0);
        // R4: down from 0 wraps to 7
        cyc(pat_dn(0), 1'b1);
        chk("R4 wrap down", int'(phase_o), 7);
        cyc(pat_up(7), 1'b1);
        chk("R4 wrap up", int'(phase_o), 0);

        // exhaustive pattern sweeps under several thresholds (R2 R3 R5)
        for (int t = 0; t < 4; t++) begin
            cyc(8'h00, 1'b0);
            thresh_i = 4'(t);
            for (int pat = 0; pat < 256; pat++) cyc(8'(pat), 1'b1);
            for (int pat = 0; pat < 256; pat++) cyc(8'(pat * 37 + 11), 1'b1);
        end

        // R9: steady bias ramps one step every T edges, both ways
        cyc(8'h00, 1'b0);
        thresh_i = 4'd2;
        p0 = m_phase;
        for (int k = 0; k < 6; k++) cyc(pat_up(m_phase), 1'b1);
        chk("R9 ramp up", int'(phase_o), (p0 + 3) % 8);
        for (int k = 0; k < 20; k++) cyc(pat_up(m_phase), 1'b1);
        chk("R9 ramp wrap", int'(phase_o), (p0 + 13) % 8);
        cyc(8'h00, 1'b0);
        p0 = m_phase;
        for (int k = 0; k < 18; k++) cyc(pat_dn(m_phase), 1'b1);
        chk("R9 ramp down", int'(phase_o), (p0 + 8 - 1) % 8);

        // R7 and R8: lock window length
        for (int ll = 0; ll < 7; ll++) begin
            cyc(8'h00, 1'b0);
            lock_len_i = 6'(ll);
            cyc(8'h00, 1'b1);           // REF exit edge, not counted
            for (int k = 1; k < ll; k++) begin
                cyc(8'h00, 1'b1);
                chk("R7 not yet locked", int'(locked_o), 0);
            end
            cyc(8'h00, 1'b1);
            chk("R8 enter lock", int'(locked_o), 1);
            thresh_i = 4'd1;
            cyc(pat_up(m_phase), 1'b1);
            chk("R7 step drops lock", int'(locked_o), 0);
        end

        // R6: reference mode ignores samples and clears the filter
        thresh_i = 4'd3;
        cyc(8'h00, 1'b0);
        cyc(pat_up(m_phase), 1'b1);
        cyc(pat_up(m_phase), 1'b1);     // accumulator now 2
        p0 = m_phase;
        for (int k = 0; k < 40; k++) cyc(8'(k * 53 + 7), 1'b0);
        chk("R6 phase frozen", int'(phase_o), p0);
        chk("R6 valid low", int'(bit_vld_o), 0);
        chk("R8 ref unlocked", int'(locked_o), 0);
        cyc(pat_up(m_phase), 1'b1);
        cyc(pat_up(m_phase), 1'b1);
        chk("R6 filter cleared", int'(phase_o), p0);
        cyc(pat_up(m_phase), 1'b1);
        chk("R3 third vote steps", int'(phase_o), (p0 + 1) % 8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule